// File: doc/BRIEF.md
# Pulse Program Front-Panel Controller

This block is the front-panel control logic for a pulse generator that keeps four stored programs. Three already-debounced button pulses come in: one steps the selection, one starts the selected program and one stops it. The block drives a program index and one-hot indicator LEDs, a run LED and a fault LED. It also sends run and halt commands to a separate pattern engine, and that engine reports back with a done pulse when a one-shot program has finished.

Programs come in two kinds, and the `CW_MASK` parameter marks which is which. A one-shot program ends when the engine asserts done. A continuous program ignores done and plays until Stop. A separate over-voltage flag comes from an external comparator. It passes through a two-flop synchroniser and then a hold-off filter. While a fault is active, playback is paused: `eng_run` drops, the run state is kept, and `run_led` stays lit. Once the flag has been clear for `CLEAR_CYC` consecutive synchronised cycles, the same program resumes.

The state machine has three states. `ST_IDLE` waits for a selection or a start. `ST_RUN` is active playback. `ST_SUSP` is playback paused by a fault. The transitions are:
- start: IDLE to RUN, on Start with no fault.
- stop: RUN or SUSP to IDLE, on Stop, with a halt pulse.
- finish: RUN to IDLE, on done for a one-shot program.
- suspend: RUN to SUSP, on fault.
- resume: SUSP to RUN, when the fault clears.

Top module: `pgm_select_ctrl`

## Requirements
- R1: After reset, `prog_idx` is 0 and `prog_led` is 4'b0001. `run_led`, `fault_led`, `eng_run` and `eng_halt` are all 0.
- R2: In IDLE, a `btn_prog` pulse advances `prog_idx` by one, wrapping from 3 to 0, in the cycle after the pulse. `prog_led` is one-hot with bit `prog_idx` set.
- R3: In IDLE with no fault, a `btn_start` pulse sets `run_led` and `eng_run` in the cycle after the pulse.
- R4: For a one-shot program (default: every index except 2), an `eng_done` pulse in RUN returns the block to IDLE. `run_led` and `eng_run` drop, and `eng_halt` stays 0.
- R5: For a continuous program (default: index 2, from `CW_MASK` bit 2), `eng_done` has no effect. A `btn_stop` pulse returns to IDLE and gives `eng_halt` high for exactly one cycle.
- R6: A `btn_stop` pulse while a one-shot program runs aborts it. The block returns to IDLE with a one-cycle `eng_halt`.
- R7: `btn_prog` is ignored outside IDLE. When `btn_prog` and `btn_start` arrive in the same IDLE cycle, the start is taken and the selection is unchanged.
- R8: `ov_flag` is synchronised by two flops. `fault_led` rises on the third rising edge after `ov_flag` goes high. In RUN, the block then enters SUSP: `eng_run` drops and `run_led` stays 1.
- R9: `fault_led` clears only after the synchronised flag has been low for `CLEAR_CYC` consecutive cycles, and a high cycle restarts the count. The block then returns from SUSP to RUN with `eng_run` high and `prog_idx` unchanged.
- R10: In IDLE, `btn_start` is ignored while `fault_led` is 1. In SUSP, `btn_stop` returns to IDLE with a one-cycle `eng_halt`.
- R11: `eng_done` in SUSP is ignored: the block stays suspended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| btn_prog | input | 1 | Debounced program-select pulse |
| btn_start | input | 1 | Debounced start pulse |
| btn_stop | input | 1 | Debounced stop pulse |
| ov_flag | input | 1 | Asynchronous over-voltage flag |
| eng_done | input | 1 | Pattern engine finished a one-shot program |
| prog_idx | output | 2 | Selected program index |
| prog_led | output | 4 | One-hot program indicators |
| run_led | output | 1 | Program running or suspended |
| fault_led | output | 1 | Filtered over-voltage fault |
| eng_run | output | 1 | Engine play enable |
| eng_halt | output | 1 | One-cycle engine abort pulse |

## Verification
The hardest state to reach from the ports is a suspension that ends by resuming rather than by a stop. A second hard case is a short over-voltage glitch arriving in the middle of the hold-off count, which must restart that count. The stimulus first starts a one-shot program and raises `ov_flag` so that the block suspends. It then drops the flag, injects a one-cycle glitch part-way through the count, and counts edges from the glitch to find exactly when `fault_led` should clear. After that it checks that playback resumes on the same index and still ends on done.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SUSP = 2'd2
    } run_state_e;

endpackage

// File: rtl/ovp_guard.sv
module ovp_guard #(
    parameter int CLEAR_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ov_async,
    output logic fault
);
    localparam int CNT_W = $clog2(CLEAR_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLEAR_CYC - 1);

    logic             meta_q;
    logic             sync_q;
    logic             fault_q;
    logic [CNT_W-1:0] clr_cnt_q;

    // two-flop synchroniser for the comparator flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= ov_async;
            sync_q <= meta_q;
        end
    end

    // fault is set at once, cleared after CLEAR_CYC quiet cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q   <= 1'b0;
            clr_cnt_q <= '0;
        end else if (sync_q) begin
            fault_q   <= 1'b1;
            clr_cnt_q <= '0;
        end else if (fault_q) begin
            if (clr_cnt_q == CNT_LAST) begin
                fault_q   <= 1'b0;
                clr_cnt_q <= '0;
            end else begin
                clr_cnt_q <= clr_cnt_q + 1'b1;
            end
        end
    end

    assign fault = fault_q;

    AST_FAULT_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_q) |-> !$past(sync_q)); // R9

    AST_FAULT_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |=> fault_q); // R8

endmodule

// File: rtl/prog_index.sv
module prog_index #(
    parameter int NUM_PROG = 4,
    parameter int IDX_W    = $clog2(NUM_PROG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    output logic [IDX_W-1:0]    idx,
    output logic [NUM_PROG-1:0] led
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_PROG - 1);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (adv) begin
            idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end
    end

    // one indicator per stored program
    for (genvar g = 0; g < NUM_PROG; g++) begin : g_led
        assign led[g] = (idx_q == IDX_W'(g));
    end

    assign idx = idx_q;

    AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(idx_q)); // R7

    AST_LED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(led) == 1); // R2

endmodule

// File: rtl/run_fsm.sv
module run_fsm
    import pgs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic btn_start,
    input  logic btn_stop,
    input  logic eng_done,
    input  logic fault,
    input  logic is_cw,
    output logic sel_en,
    output logic run_led,
    output logic eng_run,
    output logic eng_halt
);
    run_state_e state_q;
    run_state_e state_nx;
    logic       halt_req;

    always_comb begin
        state_nx = state_q;
        halt_req = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (btn_start && !fault) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (btn_stop) begin
                    state_nx = ST_IDLE;
                    halt_req = 1'b1;
                end else if (fault) begin
                    state_nx = ST_SUSP;
                end else if (eng_done && !is_cw) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_SUSP: begin
                if (btn_stop) begin
                    state_nx = ST_IDLE;
                    halt_req = 1'b1;
                end else if (!fault) begin
                    state_nx = ST_RUN;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_led  <= 1'b0;
            eng_run  <= 1'b0;
            eng_halt <= 1'b0;
        end else begin
            run_led  <= (state_nx != ST_IDLE);
            eng_run  <= (state_nx == ST_RUN);
            eng_halt <= halt_req;
        end
    end

    // selection may move only in idle and never together with a start
    assign sel_en = (state_q == ST_IDLE) && !btn_start;

    AST_HALT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_halt |=> !eng_halt); // R5

    AST_HALT_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        eng_halt |-> $past(btn_stop)); // R6

    AST_FAULT_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && fault && !btn_stop) |=> (state_q == ST_SUSP)); // R8

    AST_SUSP_IGNORES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSP && fault && !btn_stop) |=> (state_q == ST_SUSP)); // R11

    AST_NO_START_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && fault) |=> (state_q == ST_IDLE)); // R10

endmodule

// File: rtl/pgm_select_ctrl.sv
module pgm_select_ctrl #(
    parameter int              NUM_PROG  = 4,
    parameter int              IDX_W     = $clog2(NUM_PROG),
    parameter logic [NUM_PROG-1:0] CW_MASK = 4'b0100,
    parameter int              CLEAR_CYC = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                btn_prog,
    input  logic                btn_start,
    input  logic                btn_stop,
    input  logic                ov_flag,
    input  logic                eng_done,
    output logic [IDX_W-1:0]    prog_idx,
    output logic [NUM_PROG-1:0] prog_led,
    output logic                run_led,
    output logic                fault_led,
    output logic                eng_run,
    output logic                eng_halt
);
    logic fault;
    logic sel_en;
    logic is_cw;

    ovp_guard #(
        .CLEAR_CYC (CLEAR_CYC)
    ) i_ovp_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .ov_async (ov_flag),
        .fault    (fault)
    );

    prog_index #(
        .NUM_PROG (NUM_PROG),
        .IDX_W    (IDX_W)
    ) i_prog_index (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (btn_prog && sel_en),
        .idx   (prog_idx),
        .led   (prog_led)
    );

    assign is_cw = CW_MASK[prog_idx];

    run_fsm i_run_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .btn_start (btn_start),
        .btn_stop  (btn_stop),
        .eng_done  (eng_done),
        .fault     (fault),
        .is_cw     (is_cw),
        .sel_en    (sel_en),
        .run_led   (run_led),
        .eng_run   (eng_run),
        .eng_halt  (eng_halt)
    );

    assign fault_led = fault;

    AST_RUN_IMPLIES_LED: assert property (@(posedge clk) disable iff (!rst_n)
        eng_run |-> run_led); // R3

endmodule

// File: tb/test_pgm_select_ctrl.sv
module test_pgm_select_ctrl;
    localparam int C = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_prog = 1'b0, btn_start = 1'b0, btn_stop = 1'b0;
    logic       ov_flag = 1'b0, eng_done = 1'b0;
    logic [1:0] prog_idx;
    logic [3:0] prog_led;
    logic       run_led, fault_led, eng_run, eng_halt;

    int n_chk = 0;
    int n_fail = 0;
    int exp_idx = 0;

    always #2.5 clk = ~clk;

    pgm_select_ctrl #(.CLEAR_CYC(C)) i_pgm_select_ctrl (
        .clk(clk), .rst_n(rst_n), .btn_prog(btn_prog), .btn_start(btn_start),
        .btn_stop(btn_stop), .ov_flag(ov_flag), .eng_done(eng_done),
        .prog_idx(prog_idx), .prog_led(prog_led), .run_led(run_led),
        .fault_led(fault_led), .eng_run(eng_run), .eng_halt(eng_halt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse_prog();  btn_prog = 1;  tick(); btn_prog = 0;  endtask
    task automatic pulse_start(); btn_start = 1; tick(); btn_start = 0; endtask
    task automatic pulse_stop();  btn_stop = 1;  tick(); btn_stop = 0;  endtask
    task automatic pulse_done();  eng_done = 1;  tick(); eng_done = 0;  endtask

    task automatic select(input int p);
        while (exp_idx != p) begin
            pulse_prog();
            exp_idx = (exp_idx + 1) % 4;
        end
        chk("R2 select idx", prog_idx, p);
    endtask

    task automatic t_reset();
        chk("R1 idx", prog_idx, 0);
        chk("R1 led", prog_led, 4'b0001);
        chk("R1 run_led", run_led, 0);
        chk("R1 fault_led", fault_led, 0);
        chk("R1 eng_run", eng_run, 0);
        chk("R1 eng_halt", eng_halt, 0);
    endtask

    task automatic t_cycle();
        for (int k = 1; k <= 4; k++) begin
            pulse_prog();
            exp_idx = k % 4;
            chk("R2 idx step", prog_idx, exp_idx);
            chk("R2 led onehot", prog_led, 1 << exp_idx);
        end
    endtask

    task automatic t_oneshot();
        select(1);
        pulse_start();
        chk("R3 run_led", run_led, 1);
        chk("R3 eng_run", eng_run, 1);
        pulse_prog();
        chk("R7 prog ignored while running", prog_idx, 1);
        pulse_done();
        chk("R4 run_led off", run_led, 0);
        chk("R4 eng_run off", eng_run, 0);
        chk("R4 no halt", eng_halt, 0);
    endtask

    task automatic t_stop_oneshot();
        select(0);
        pulse_start();
        tick(3);
        chk("R6 still running", eng_run, 1);
        pulse_stop();
        chk("R6 halt", eng_halt, 1);
        chk("R6 run_led off", run_led, 0);
        tick();
        chk("R6 halt one cycle", eng_halt, 0);
    endtask

    task automatic t_cw();
        select(2);
        pulse_start();
        pulse_done();
        tick(2);
        chk("R5 done ignored run_led", run_led, 1);
        chk("R5 done ignored eng_run", eng_run, 1);
        pulse_stop();
        chk("R5 halt", eng_halt, 1);
        chk("R5 run_led off", run_led, 0);
        tick();
        chk("R5 halt one cycle", eng_halt, 0);
    endtask

    task automatic t_start_and_prog();
        select(3);
        btn_prog = 1; btn_start = 1;
        tick();
        btn_prog = 0; btn_start = 0;
        chk("R7 start wins idx kept", prog_idx, 3);
        chk("R7 start taken", eng_run, 1);
        pulse_done();
        chk("R4 back to idle", run_led, 0);
    endtask

    task automatic t_fault_resume();
        select(0);
        pulse_start();
        ov_flag = 1;
        tick(2);
        chk("R8 fault not yet", fault_led, 0);
        tick();
        chk("R8 fault set", fault_led, 1);
        tick();
        chk("R8 eng_run paused", eng_run, 0);
        chk("R8 run_led kept", run_led, 1);
        pulse_done();
        chk("R11 done ignored in susp", run_led, 1);
        chk("R11 still paused", eng_run, 0);
        pulse_prog();
        chk("R7 prog ignored in susp", prog_idx, 0);
        ov_flag = 0;
        tick(C / 2);
        ov_flag = 1;
        tick();
        ov_flag = 0;
        tick(C + 1);
        chk("R9 glitch restarts count", fault_led, 1);
        tick();
        chk("R9 fault cleared", fault_led, 0);
        tick();
        chk("R9 resumed eng_run", eng_run, 1);
        chk("R9 same program", prog_idx, 0);
        pulse_done();
        chk("R4 done after resume", run_led, 0);
    endtask

    task automatic t_fault_idle_and_stop();
        ov_flag = 1;
        tick(4);
        chk("R10 fault in idle", fault_led, 1);
        pulse_start();
        tick();
        chk("R10 start ignored", run_led, 0);
        ov_flag = 0;
        tick(C + 4);
        chk("R9 fault cleared idle", fault_led, 0);
        pulse_start();
        ov_flag = 1;
        tick(5);
        chk("R8 suspended", eng_run, 0);
        pulse_stop();
        chk("R10 stop in susp halt", eng_halt, 1);
        chk("R10 stop in susp idle", run_led, 0);
        ov_flag = 0;
        tick(C + 4);
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        tick();
        t_reset();
        t_cycle();
        t_oneshot();
        t_stop_oneshot();
        t_cw();
        t_start_and_prog();
        t_fault_resume();
        t_fault_idle_and_stop();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule